// File: doc/BRIEF.md
# Synchronous Exception Priority Selector

This block settles which synchronous exception an instruction reports when its fetch and its explicit memory access raise several fault conditions at once. Each fault detector drives one request bit. The block also reads a few access-type qualifiers: whether the access writes memory, whether it is a capability load and whether its loaded tag is checked, and whether it is a capability store and whether its stored tag is set. From these it returns one winning cause code, a valid bit and a one-hot vector that names the winning priority slot.

The fetch side is ranked first. An instruction address breakpoint comes first. A fault from the capability checks on the program-counter capability comes next, then fetch translation faults, then the fetch physical access fault. The explicit access is ranked after the fetch. Its data breakpoint comes first, then an optional early misaligned slot, then translation faults, then the physical access fault, then a late misaligned slot. A page-table fault that depends on a checked loaded tag comes last.

A capability page-table fault whose tag handling puts it in the high class ranks level with a normal page fault and uses the same cause code. When both are present, a side flag marks that both faults must be recorded. The whole block is combinational.

Top module: `sync_exc_prio`

## Requirements
- R1: When `fetchBkpt` is set, the result is cause 3 and `winOneHot` bit 0, whatever other requests are present.
- R2: Without R1, `fetchCapFault` gives cause `CAP_CAUSE` (`winOneHot` bit 1). It wins over every fetch translation, fetch physical and explicit-access request.
- R3: A fetch translation fault (`winOneHot` bit 2) gives cause 12 when `fetchPageFault` is set and 1 when only `fetchXlatAccFault` is set. Both rank above `fetchPhysAccFault`, which gives cause 1 on bit 3.
- R4: `memBkpt` gives cause 3 on bit 4. It ranks below all fetch faults and above misaligned, translation and physical explicit-access faults.
- R5: With `EARLY_MISALIGN`=1, `memMisaligned` wins on bit 5, ahead of explicit translation faults. With `EARLY_MISALIGN`=0 it wins on bit 8, behind the physical access fault. The cause is 4 for a load and 6 when `accIsStore`=1.
- R6: An explicit translation fault wins on bit 6. A page fault gives cause 13 for a load or 15 for a store. A translation access fault gives 5 or 7, and a page fault beats a translation access fault.
- R7: `memCapPteFault` is in the high class when (`capLoad` and not `loadTagChecked`) or (`capStore` and `storeTagSet`). It then wins on bit 6 with the page-fault code (13 or 15) and beats the physical access fault.
- R8: `pteAlsoFlag` is 1 only when bit 6 wins and both `memPageFault` and a high-class capability page-table fault are present. In every other case it is 0.
- R9: `memCapPteFault` with `capLoad` and `loadTagChecked` both set, and not in the high class, wins only at the lowest rank: bit 9, cause 13. When neither qualification holds, `memCapPteFault` is ignored.
- R10: With no active request, `excValid`, `excCause`, `winOneHot` and `pteAlsoFlag` are all 0. Otherwise `excValid` is 1 and `winOneHot` has exactly one bit set.
- R11: `memPhysAccFault` wins on bit 7 with cause 5 for a load or 7 for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetchBkpt | input | 1 | Instruction address breakpoint hit |
| fetchCapFault | input | 1 | Program-counter capability check failed |
| fetchPageFault | input | 1 | Page fault during fetch translation |
| fetchXlatAccFault | input | 1 | Access fault during fetch translation |
| fetchPhysAccFault | input | 1 | Access fault on fetch physical address |
| memBkpt | input | 1 | Load/store/AMO address breakpoint hit |
| memMisaligned | input | 1 | Explicit access address misaligned |
| memPageFault | input | 1 | Page fault during explicit-access translation |
| memCapPteFault | input | 1 | Capability page-table fault raised |
| memXlatAccFault | input | 1 | Access fault during explicit-access translation |
| memPhysAccFault | input | 1 | Access fault on explicit physical address |
| accIsStore | input | 1 | Explicit access is a store or AMO |
| capLoad | input | 1 | Access loads a capability |
| loadTagChecked | input | 1 | Loaded tag is checked |
| capStore | input | 1 | Access stores a capability |
| storeTagSet | input | 1 | Stored capability tag is set |
| excValid | output | 1 | An exception is selected |
| excCause | output | CAUSE_W | Winning cause code |
| winOneHot | output | 10 | Winning priority slot, one-hot |
| pteAlsoFlag | output | 1 | Both page fault kinds must be recorded |

## Verification
The bench builds two copies side by side. One has `EARLY_MISALIGN`=1 and `CAP_CAUSE`=28. The other has `EARLY_MISALIGN`=0 and `CAP_CAUSE`=33. Every stimulus is applied to both, so both misaligned slots (bits 5 and 8) are reached, and so is the ordering of misalignment against the translation and physical faults. The two different capability cause values show that the parameter reaches the output.

// File: rtl/sync_exc_pkg.sv
package sync_exc_pkg;

  localparam int NUM_SLOTS = 10;

  // Slot indices, highest priority at index 0
  localparam int SLOT_FETCH_BKPT   = 0;
  localparam int SLOT_FETCH_CAP    = 1;
  localparam int SLOT_FETCH_XLAT   = 2;
  localparam int SLOT_FETCH_PHYS   = 3;
  localparam int SLOT_MEM_BKPT     = 4;
  localparam int SLOT_MIS_EARLY    = 5;
  localparam int SLOT_MEM_XLAT     = 6;
  localparam int SLOT_MEM_PHYS     = 7;
  localparam int SLOT_MIS_LATE     = 8;
  localparam int SLOT_CAP_PTE_LOW  = 9;

  // Cause code values
  localparam int CODE_FETCH_ACC  = 1;
  localparam int CODE_BKPT       = 3;
  localparam int CODE_LD_MIS     = 4;
  localparam int CODE_LD_ACC     = 5;
  localparam int CODE_ST_MIS     = 6;
  localparam int CODE_ST_ACC     = 7;
  localparam int CODE_FETCH_PG   = 12;
  localparam int CODE_LD_PG      = 13;
  localparam int CODE_ST_PG      = 15;

  // Strobes from control to datapath
  typedef struct packed {
    logic isStore;
    logic fetchXlatPage;
    logic memXlatPage;
    logic pteBoth;
  } strobes_t;

endpackage

// File: rtl/sync_exc_ctrl.sv
module sync_exc_ctrl
  import sync_exc_pkg::*;
#(
  parameter bit EARLY_MISALIGN = 1'b1
) (
  input  logic                 fetchBkpt,
  input  logic                 fetchCapFault,
  input  logic                 fetchPageFault,
  input  logic                 fetchXlatAccFault,
  input  logic                 fetchPhysAccFault,
  input  logic                 memBkpt,
  input  logic                 memMisaligned,
  input  logic                 memPageFault,
  input  logic                 memCapPteFault,
  input  logic                 memXlatAccFault,
  input  logic                 memPhysAccFault,
  input  logic                 accIsStore,
  input  logic                 capLoad,
  input  logic                 loadTagChecked,
  input  logic                 capStore,
  input  logic                 storeTagSet,
  output logic [NUM_SLOTS-1:0] slotReq,
  output strobes_t             strobes
);

  logic capPteHigh;
  logic capPteLow;
  logic misEarly;
  logic misLate;

  // Tag-handling class of the capability page-table fault
  always_comb begin
    capPteHigh = memCapPteFault &
                 ((capLoad & ~loadTagChecked) | (capStore & storeTagSet));
    capPteLow  = memCapPteFault & capLoad & loadTagChecked;
  end

  // Misaligned slot placement chosen by parameter
  generate
    if (EARLY_MISALIGN) begin : g_misEarly
      assign misEarly = memMisaligned;
      assign misLate  = 1'b0;
    end else begin : g_misLate
      assign misEarly = 1'b0;
      assign misLate  = memMisaligned;
    end
  endgenerate

  always_comb begin
    slotReq                   = '0;
    slotReq[SLOT_FETCH_BKPT]  = fetchBkpt;
    slotReq[SLOT_FETCH_CAP]   = fetchCapFault;
    slotReq[SLOT_FETCH_XLAT]  = fetchPageFault | fetchXlatAccFault;
    slotReq[SLOT_FETCH_PHYS]  = fetchPhysAccFault;
    slotReq[SLOT_MEM_BKPT]    = memBkpt;
    slotReq[SLOT_MIS_EARLY]   = misEarly;
    slotReq[SLOT_MEM_XLAT]    = memPageFault | capPteHigh | memXlatAccFault;
    slotReq[SLOT_MEM_PHYS]    = memPhysAccFault;
    slotReq[SLOT_MIS_LATE]    = misLate;
    slotReq[SLOT_CAP_PTE_LOW] = capPteLow;
  end

  always_comb begin
    strobes.isStore       = accIsStore;
    strobes.fetchXlatPage = fetchPageFault;
    strobes.memXlatPage   = memPageFault | capPteHigh;
    strobes.pteBoth       = memPageFault & capPteHigh;
  end

  always_comb begin
    // R9
    low_class_chk: assert (!slotReq[SLOT_CAP_PTE_LOW] || (capLoad && loadTagChecked))
      else $error("low-class page-table request without checked capability load");
    // R5
    mis_slot_chk: assert (!(slotReq[SLOT_MIS_EARLY] && slotReq[SLOT_MIS_LATE]))
      else $error("misaligned raised in both slots");
  end

endmodule

// File: rtl/sync_exc_pick.sv
module sync_exc_pick #(
  parameter int WIDTH = 10
) (
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] win
);

  logic [WIDTH:0] seen;

  assign seen[0] = 1'b0;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slot
      assign seen[i+1] = seen[i] | req[i];
      assign win[i]    = req[i] & ~seen[i];
    end
  endgenerate

  always_comb begin
    // R10
    win_onehot_chk: assert ($onehot0(win))
      else $error("more than one winner");
    // R10
    win_subset_chk: assert ((win & ~req) == '0)
      else $error("winner without request");
    // R10
    win_present_chk: assert ((req == '0) || (win != '0))
      else $error("request without winner");
  end

endmodule

// File: rtl/sync_exc_dp.sv
module sync_exc_dp
  import sync_exc_pkg::*;
#(
  parameter int CAUSE_W   = 6,
  parameter int CAP_CAUSE = 28
) (
  input  logic [NUM_SLOTS-1:0] win,
  input  strobes_t             strobes,
  output logic                 excValid,
  output logic [CAUSE_W-1:0]   excCause,
  output logic                 pteAlsoFlag
);

  logic [CAUSE_W-1:0] slotCode [NUM_SLOTS];
  logic [CAUSE_W-1:0] misCode;
  logic [CAUSE_W-1:0] accCode;
  logic [CAUSE_W-1:0] pgCode;

  always_comb begin
    misCode = strobes.isStore ? CAUSE_W'(CODE_ST_MIS) : CAUSE_W'(CODE_LD_MIS);
    accCode = strobes.isStore ? CAUSE_W'(CODE_ST_ACC) : CAUSE_W'(CODE_LD_ACC);
    pgCode  = strobes.isStore ? CAUSE_W'(CODE_ST_PG)  : CAUSE_W'(CODE_LD_PG);
  end

  always_comb begin
    slotCode[SLOT_FETCH_BKPT]  = CAUSE_W'(CODE_BKPT);
    slotCode[SLOT_FETCH_CAP]   = CAUSE_W'(CAP_CAUSE);
    slotCode[SLOT_FETCH_XLAT]  = strobes.fetchXlatPage ? CAUSE_W'(CODE_FETCH_PG)
                                                       : CAUSE_W'(CODE_FETCH_ACC);
    slotCode[SLOT_FETCH_PHYS]  = CAUSE_W'(CODE_FETCH_ACC);
    slotCode[SLOT_MEM_BKPT]    = CAUSE_W'(CODE_BKPT);
    slotCode[SLOT_MIS_EARLY]   = misCode;
    slotCode[SLOT_MEM_XLAT]    = strobes.memXlatPage ? pgCode : accCode;
    slotCode[SLOT_MEM_PHYS]    = accCode;
    slotCode[SLOT_MIS_LATE]    = misCode;
    slotCode[SLOT_CAP_PTE_LOW] = CAUSE_W'(CODE_LD_PG);
  end

  // AND-OR mux over the one-hot winner
  always_comb begin
    excCause = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      excCause = excCause | (slotCode[i] & {CAUSE_W{win[i]}});
    end
    excValid    = |win;
    pteAlsoFlag = win[SLOT_MEM_XLAT] & strobes.pteBoth;
  end

  always_comb begin
    // R10
    idle_zero_chk: assert (excValid || (excCause == '0 && !pteAlsoFlag))
      else $error("idle output not zero");
    // R8
    flag_code_chk: assert (!pteAlsoFlag ||
                           excCause == CAUSE_W'(CODE_LD_PG) || excCause == CAUSE_W'(CODE_ST_PG))
      else $error("dual-record flag without page-fault cause");
  end

endmodule

// File: rtl/sync_exc_prio.sv
module sync_exc_prio
  import sync_exc_pkg::*;
#(
  parameter int CAUSE_W        = 6,
  parameter int CAP_CAUSE      = 28,
  parameter bit EARLY_MISALIGN = 1'b1
) (
  input  logic                 fetchBkpt,
  input  logic                 fetchCapFault,
  input  logic                 fetchPageFault,
  input  logic                 fetchXlatAccFault,
  input  logic                 fetchPhysAccFault,
  input  logic                 memBkpt,
  input  logic                 memMisaligned,
  input  logic                 memPageFault,
  input  logic                 memCapPteFault,
  input  logic                 memXlatAccFault,
  input  logic                 memPhysAccFault,
  input  logic                 accIsStore,
  input  logic                 capLoad,
  input  logic                 loadTagChecked,
  input  logic                 capStore,
  input  logic                 storeTagSet,
  output logic                 excValid,
  output logic [CAUSE_W-1:0]   excCause,
  output logic [NUM_SLOTS-1:0] winOneHot,
  output logic                 pteAlsoFlag
);

  logic [NUM_SLOTS-1:0] slotReq;
  strobes_t             strobes;

  sync_exc_ctrl #(.EARLY_MISALIGN(EARLY_MISALIGN)) u_ctrl (
    .fetchBkpt         (fetchBkpt),
    .fetchCapFault     (fetchCapFault),
    .fetchPageFault    (fetchPageFault),
    .fetchXlatAccFault (fetchXlatAccFault),
    .fetchPhysAccFault (fetchPhysAccFault),
    .memBkpt           (memBkpt),
    .memMisaligned     (memMisaligned),
    .memPageFault      (memPageFault),
    .memCapPteFault    (memCapPteFault),
    .memXlatAccFault   (memXlatAccFault),
    .memPhysAccFault   (memPhysAccFault),
    .accIsStore        (accIsStore),
    .capLoad           (capLoad),
    .loadTagChecked    (loadTagChecked),
    .capStore          (capStore),
    .storeTagSet       (storeTagSet),
    .slotReq           (slotReq),
    .strobes           (strobes)
  );

  sync_exc_pick #(.WIDTH(NUM_SLOTS)) u_pick (
    .req (slotReq),
    .win (winOneHot)
  );

  sync_exc_dp #(.CAUSE_W(CAUSE_W), .CAP_CAUSE(CAP_CAUSE)) u_dp (
    .win         (winOneHot),
    .strobes     (strobes),
    .excValid    (excValid),
    .excCause    (excCause),
    .pteAlsoFlag (pteAlsoFlag)
  );

  always_comb begin
    // R1
    fetch_bkpt_top_chk: assert (!fetchBkpt || winOneHot[SLOT_FETCH_BKPT])
      else $error("fetch breakpoint did not win");
    // R8
    flag_src_chk: assert (!pteAlsoFlag || (memPageFault && memCapPteFault))
      else $error("dual-record flag without both faults");
  end

endmodule

// File: tb/sim_sync_exc_prio.sv
module sim_sync_exc_prio;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic fetchBkpt, fetchCapFault, fetchPageFault, fetchXlatAccFault, fetchPhysAccFault;
  logic memBkpt, memMisaligned, memPageFault, memCapPteFault, memXlatAccFault, memPhysAccFault;
  logic accIsStore, capLoad, loadTagChecked, capStore, storeTagSet;

  logic       v0, v1, f0, f1;
  logic [5:0] c0, c1;
  logic [9:0] w0, w1;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  sync_exc_prio #(.CAUSE_W(6), .CAP_CAUSE(28), .EARLY_MISALIGN(1'b1)) u0 (
    .fetchBkpt(fetchBkpt), .fetchCapFault(fetchCapFault), .fetchPageFault(fetchPageFault),
    .fetchXlatAccFault(fetchXlatAccFault), .fetchPhysAccFault(fetchPhysAccFault),
    .memBkpt(memBkpt), .memMisaligned(memMisaligned), .memPageFault(memPageFault),
    .memCapPteFault(memCapPteFault), .memXlatAccFault(memXlatAccFault),
    .memPhysAccFault(memPhysAccFault), .accIsStore(accIsStore), .capLoad(capLoad),
    .loadTagChecked(loadTagChecked), .capStore(capStore), .storeTagSet(storeTagSet),
    .excValid(v0), .excCause(c0), .winOneHot(w0), .pteAlsoFlag(f0)
  );

  sync_exc_prio #(.CAUSE_W(6), .CAP_CAUSE(33), .EARLY_MISALIGN(1'b0)) u1 (
    .fetchBkpt(fetchBkpt), .fetchCapFault(fetchCapFault), .fetchPageFault(fetchPageFault),
    .fetchXlatAccFault(fetchXlatAccFault), .fetchPhysAccFault(fetchPhysAccFault),
    .memBkpt(memBkpt), .memMisaligned(memMisaligned), .memPageFault(memPageFault),
    .memCapPteFault(memCapPteFault), .memXlatAccFault(memXlatAccFault),
    .memPhysAccFault(memPhysAccFault), .accIsStore(accIsStore), .capLoad(capLoad),
    .loadTagChecked(loadTagChecked), .capStore(capStore), .storeTagSet(storeTagSet),
    .excValid(v1), .excCause(c1), .winOneHot(w1), .pteAlsoFlag(f1)
  );

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clearAll();
    {fetchBkpt, fetchCapFault, fetchPageFault, fetchXlatAccFault, fetchPhysAccFault} = '0;
    {memBkpt, memMisaligned, memPageFault, memCapPteFault, memXlatAccFault, memPhysAccFault} = '0;
    {accIsStore, capLoad, loadTagChecked, capStore, storeTagSet} = '0;
  endtask

  // Inputs change just after a rising edge, outputs sampled at the falling edge
  task automatic applyEdge();
    @(negedge clk);
  endtask

  task automatic setupEdge();
    @(posedge clk);
    #1;
    clearAll();
  endtask

  // Expectations for both copies: cause, winner bit index (-1 = none), flag
  task automatic expectBoth(input string tag, input int cause0, input int bit0,
                            input int cause1, input int bit1, input int flag);
    applyEdge();
    check({tag, " u0 cause"}, int'(c0), cause0);
    check({tag, " u0 win"},   int'(w0), (bit0 < 0) ? 0 : (1 << bit0));
    check({tag, " u0 flag"},  int'(f0), flag);
    check({tag, " u1 cause"}, int'(c1), cause1);
    check({tag, " u1 win"},   int'(w1), (bit1 < 0) ? 0 : (1 << bit1));
    check({tag, " u1 flag"},  int'(f1), flag);
    check({tag, " u0 valid"}, int'(v0), (bit0 < 0) ? 0 : 1);
    check({tag, " u1 valid"}, int'(v1), (bit1 < 0) ? 0 : 1);
  endtask

  task automatic tIdle();
    setupEdge();
    expectBoth("R10 idle", 0, -1, 0, -1, 0);
  endtask

  task automatic tFetchBkpt();
    setupEdge();
    fetchBkpt = 1; fetchCapFault = 1; fetchPageFault = 1; memBkpt = 1;
    memMisaligned = 1; memPageFault = 1; memPhysAccFault = 1;
    expectBoth("R1 fetch bkpt", 3, 0, 3, 0, 0);
  endtask

  task automatic tFetchCap();
    setupEdge();
    fetchCapFault = 1; fetchPageFault = 1; fetchPhysAccFault = 1; memBkpt = 1;
    memPageFault = 1; memCapPteFault = 1; capLoad = 1; loadTagChecked = 1;
    expectBoth("R2 fetch cap", 28, 1, 33, 1, 0);
  endtask

  task automatic tFetchXlat();
    setupEdge();
    fetchPageFault = 1; fetchXlatAccFault = 1; fetchPhysAccFault = 1; memBkpt = 1;
    expectBoth("R3 fetch page", 12, 2, 12, 2, 0);
    setupEdge();
    fetchXlatAccFault = 1; fetchPhysAccFault = 1; memPageFault = 1;
    expectBoth("R3 fetch xlat acc", 1, 2, 1, 2, 0);
    setupEdge();
    fetchPhysAccFault = 1; memBkpt = 1;
    expectBoth("R3 fetch phys", 1, 3, 1, 3, 0);
  endtask

  task automatic tMemBkpt();
    setupEdge();
    memBkpt = 1; memMisaligned = 1; memPageFault = 1; memPhysAccFault = 1;
    expectBoth("R4 mem bkpt", 3, 4, 3, 4, 0);
  endtask

  task automatic tMisalign();
    setupEdge();
    memMisaligned = 1; memPageFault = 1;
    expectBoth("R5 misalign vs page", 4, 5, 13, 6, 0);
    setupEdge();
    memMisaligned = 1; memPhysAccFault = 1; accIsStore = 1;
    expectBoth("R5 R11 misalign vs phys", 6, 5, 7, 7, 0);
    setupEdge();
    memMisaligned = 1; accIsStore = 1;
    expectBoth("R5 misalign alone", 6, 5, 6, 8, 0);
  endtask

  task automatic tMemXlat();
    setupEdge();
    memPageFault = 1; memPhysAccFault = 1;
    expectBoth("R6 load page", 13, 6, 13, 6, 0);
    setupEdge();
    memPageFault = 1; memXlatAccFault = 1; accIsStore = 1;
    expectBoth("R6 store page over acc", 15, 6, 15, 6, 0);
    setupEdge();
    memXlatAccFault = 1; memPhysAccFault = 1; accIsStore = 1;
    expectBoth("R6 store xlat acc", 7, 6, 7, 6, 0);
    setupEdge();
    memPhysAccFault = 1;
    expectBoth("R11 load phys", 5, 7, 5, 7, 0);
  endtask

  task automatic tCapPteHigh();
    setupEdge();
    memCapPteFault = 1; capLoad = 1; memPhysAccFault = 1;
    expectBoth("R7 cap load unchecked", 13, 6, 13, 6, 0);
    setupEdge();
    memCapPteFault = 1; capStore = 1; storeTagSet = 1; accIsStore = 1; memPhysAccFault = 1;
    expectBoth("R7 cap store tag set", 15, 6, 15, 6, 0);
    setupEdge();
    memCapPteFault = 1; capStore = 1; accIsStore = 1;
    expectBoth("R9 cap pte ignored", 0, -1, 0, -1, 0);
  endtask

  task automatic tBoth();
    setupEdge();
    memPageFault = 1; memCapPteFault = 1; capLoad = 1;
    expectBoth("R8 both recorded", 13, 6, 13, 6, 1);
    setupEdge();
    memPageFault = 1; memCapPteFault = 1; capLoad = 1; fetchBkpt = 1;
    expectBoth("R8 flag masked", 3, 0, 3, 0, 0);
    setupEdge();
    memPageFault = 1; memCapPteFault = 1; capLoad = 1; loadTagChecked = 1;
    expectBoth("R8 low class no flag", 13, 6, 13, 6, 0);
  endtask

  task automatic tCapPteLow();
    setupEdge();
    memCapPteFault = 1; capLoad = 1; loadTagChecked = 1;
    expectBoth("R9 low class alone", 13, 9, 13, 9, 0);
    setupEdge();
    memCapPteFault = 1; capLoad = 1; loadTagChecked = 1; memMisaligned = 1;
    expectBoth("R9 low below misalign", 4, 5, 4, 8, 0);
    setupEdge();
    memCapPteFault = 1; capLoad = 1; loadTagChecked = 1; capStore = 1; storeTagSet = 1;
    accIsStore = 1;
    expectBoth("R7 high over low", 15, 6, 15, 6, 0);
  endtask

  initial begin
    clearAll();
    tIdle();
    tFetchBkpt();
    tFetchCap();
    tFetchXlat();
    tMemBkpt();
    tMisalign();
    tMemXlat();
    tCapPteHigh();
    tBoth();
    tCapPteLow();
    tIdle();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule